// File: doc/BRIEF.md
# Paged Host Register Window with Remote DMA Port

This block is the host side of a network controller's buffer interface. The host sees a 16-offset register window and one data port. The top two bits of the command register select which bank of registers the other fifteen offsets reach. To move data into or out of the on-chip buffer, the host loads a start address and a byte count. It then reads or writes the data port repeatedly. Each access moves one, two or four bytes. The address steps forward and wraps around the receive ring, and the count steps down.

When the count runs out, the block sets a completion flag in the interrupt status register. The interrupt output is raised whenever an unmasked status bit among the low seven is set. The host clears status bits by writing ones to them.

Buffer storage is 32 bytes of station-address area at addresses 0x000–0x01F, plus a packet region at 0x400–0x7FF (4 pages of 256 bytes starting at page 4). No other address is backed by storage.

Top module: `rdma_port`

## Requirements
- R1: After reset, the command register reads 0x01, the status register reads 0x80, both address bytes and the count read as 0, and `irq` is low.
- R2: Offset 0 is the command register on every page, and command bits 7:6 select the page. Page 0 writable registers:
  - offset 1: start page
  - offset 2: stop page
  - offset 7: status
  - offsets 8/9: address low/high
  - offsets 0x0A/0x0B: count low/high
  - offset 0x0E: configuration
  - offset 0x0F: mask

  Page 0 readable registers are offset 7 (status) and offsets 8/9 (address). Page 2 reads start page, stop page, configuration and mask at offsets 1, 2, 0x0E and 0x0F. Writes on pages 1–3 other than to offset 0 change nothing. Every other read returns 0x00.
- R3: Access size:
  - A wide access (`dpWide`=1) moves 4 bytes.
  - A narrow access moves 2 bytes when configuration bit 0 is 1, and 1 byte otherwise.
  - 2- and 4-byte accesses use the address with bit 0 cleared.
  - Byte k of the access sits at bits 8k+7:8k.
  - Unused upper bytes read as 0.
- R4: After each port access the address advances by the access size. If the result equals stop page × 256, the address is reloaded with start page × 256.
- R5: If the count is at most the access size, an access sets the count to 0 and sets status bit 6. Otherwise the count falls by the access size.
- R6: A port write while the count is 0 leaves the buffer, the address and the count unchanged. A port read always advances.
- R7: A command write with bit 0 (stop) clear clears status bit 7. If such a write also has bit 3 or bit 4 set while the count is 0, it sets status bit 6.
- R8: A status write clears each of bits 6:0 that is written as 1. Bit 7 is unaffected by a status write.
- R9: `irq` is high exactly when (status AND mask) is nonzero over bits 6:0.
- R10: A byte lane whose address lies outside 0x000–0x01F and 0x400–0x7FF reads 0xFF, and writes to it are dropped.
- R11: A start-page or stop-page write with a value above 8 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register window offset |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| dpWr | input | 1 | Data port write strobe |
| dpRd | input | 1 | Data port read strobe |
| dpWide | input | 1 | 1 = 4-byte access, 0 = narrow |
| dpWdata | input | 32 | Data port write data, little-endian |
| dpRdata | output | 32 | Data port read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, assertions check the following:
- The completion flag follows an exhausted count.
- A command write without stop removes the reset flag, and that flag otherwise persists.
- Written-one status bits clear.
- A write with zero count freezes the address and count.
- The count only falls on an access.
- The address never rests on the stop address after an access.

The bench scenarios cover what needs stored data to observe: byte-lane ordering, even alignment of word accesses, reads of unbacked addresses, ring wrap seen through the address registers, and page selection of the register window.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;
  localparam int CMD_STOP   = 0;
  localparam int CMD_RREAD  = 3;
  localparam int CMD_RWRITE = 4;
  localparam int ST_DONE    = 6;
  localparam int ST_RESET   = 7;

  localparam logic [3:0] OFF_CMD   = 4'h0;
  localparam logic [3:0] OFF_PSTRT = 4'h1;
  localparam logic [3:0] OFF_PSTOP = 4'h2;
  localparam logic [3:0] OFF_STAT  = 4'h7;
  localparam logic [3:0] OFF_ADRL  = 4'h8;
  localparam logic [3:0] OFF_ADRH  = 4'h9;
  localparam logic [3:0] OFF_CNTL  = 4'hA;
  localparam logic [3:0] OFF_CNTH  = 4'hB;
  localparam logic [3:0] OFF_CFG   = 4'hE;
  localparam logic [3:0] OFF_MASK  = 4'hF;

  typedef struct packed {
    logic       adrLoWr;
    logic       adrHiWr;
    logic       cntLoWr;
    logic       cntHiWr;
    logic [7:0] data;
    logic [7:0] startPage;
    logic [7:0] stopPage;
    logic       wordMode;
  } rdma_strobe_t;
endpackage

// File: rtl/rdma_ctrl.sv
`timescale 1ns/1ps
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int END_PAGE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWdata,
  input  logic [ADDR_W-1:0] rsar,
  input  logic              cntZero,
  input  logic              dmaDone,
  output logic [7:0]        regRdata,
  output rdma_strobe_t      strobe,
  output logic              irq
);
  localparam logic [7:0] END_PG = 8'(END_PAGE);

  logic [7:0] cmdQ, statQ, maskQ, cfgQ, startQ, stopQ;
  logic [7:0] statNext;
  logic [1:0] page;
  logic       wrCmd, wrP0, cmdRun;

  assign page   = cmdQ[7:6];
  assign wrCmd  = regWr && (regAddr == OFF_CMD);
  assign wrP0   = regWr && (regAddr != OFF_CMD) && (page == 2'd0);
  assign cmdRun = wrCmd && !regWdata[CMD_STOP];

  always_comb begin
    statNext = statQ;
    if (cmdRun) begin
      statNext[ST_RESET] = 1'b0;
      if ((regWdata[CMD_RREAD] || regWdata[CMD_RWRITE]) && cntZero)
        statNext[ST_DONE] = 1'b1;
    end
    if (wrP0 && regAddr == OFF_STAT)
      statNext[6:0] = statQ[6:0] & ~regWdata[6:0];
    if (dmaDone)
      statNext[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= 8'h01;
      statQ  <= 8'h80;
      maskQ  <= 8'h00;
      cfgQ   <= 8'h00;
      startQ <= 8'h00;
      stopQ  <= 8'h00;
    end else begin
      statQ <= statNext;
      if (wrCmd) cmdQ <= regWdata;
      if (wrP0) begin
        case (regAddr)
          OFF_PSTRT: if (regWdata <= END_PG) startQ <= regWdata;
          OFF_PSTOP: if (regWdata <= END_PG) stopQ <= regWdata;
          OFF_CFG:   cfgQ  <= regWdata;
          OFF_MASK:  maskQ <= regWdata;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.adrLoWr   = wrP0 && regAddr == OFF_ADRL;
    strobe.adrHiWr   = wrP0 && regAddr == OFF_ADRH;
    strobe.cntLoWr   = wrP0 && regAddr == OFF_CNTL;
    strobe.cntHiWr   = wrP0 && regAddr == OFF_CNTH;
    strobe.data      = regWdata;
    strobe.startPage = startQ;
    strobe.stopPage  = stopQ;
    strobe.wordMode  = cfgQ[0];
  end

  always_comb begin
    regRdata = 8'h00;
    if (regAddr == OFF_CMD) regRdata = cmdQ;
    else if (page == 2'd0) begin
      case (regAddr)
        OFF_STAT: regRdata = statQ;
        OFF_ADRL: regRdata = rsar[7:0];
        OFF_ADRH: regRdata = 8'(rsar >> 8);
        default:  regRdata = 8'h00;
      endcase
    end else if (page == 2'd2) begin
      case (regAddr)
        OFF_PSTRT: regRdata = startQ;
        OFF_PSTOP: regRdata = stopQ;
        OFF_CFG:   regRdata = cfgQ;
        OFF_MASK:  regRdata = maskQ;
        default:   regRdata = 8'h00;
      endcase
    end
  end

  assign irq = |(statQ[6:0] & maskQ[6:0]);

  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> statQ[ST_DONE]);
  p_run_clears_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdRun |=> !statQ[ST_RESET]);
  p_reset_flag_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[ST_RESET] && !cmdRun) |=> statQ[ST_RESET]);
  p_w1c_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrP0 && regAddr == OFF_STAT && regWdata[ST_DONE] && !dmaDone) |=> !statQ[ST_DONE]);
endmodule

// File: rtl/rdma_datapath.sv
`timescale 1ns/1ps
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int CNT_W           = 16,
  parameter int PROM_BYTES      = 32,
  parameter int PMEM_START_PAGE = 4,
  parameter int PMEM_PAGES      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdma_strobe_t      strobe,
  input  logic              dpWr,
  input  logic              dpRd,
  input  logic              dpWide,
  input  logic [31:0]       dpWdata,
  output logic [31:0]       dpRdata,
  output logic [ADDR_W-1:0] rsar,
  output logic              cntZero,
  output logic              dmaDone
);
  localparam int LANES      = 4;
  localparam int PMEM_BYTES = PMEM_PAGES * 256;
  localparam int PM_AW      = $clog2(PMEM_BYTES);
  localparam int PR_AW      = $clog2(PROM_BYTES);
  localparam logic [ADDR_W-1:0] PROM_END = ADDR_W'(PROM_BYTES);
  localparam logic [ADDR_W-1:0] PMEM_LO  = ADDR_W'(PMEM_START_PAGE * 256);
  localparam logic [ADDR_W-1:0] PMEM_HI  = ADDR_W'((PMEM_START_PAGE + PMEM_PAGES) * 256);

  logic [7:0] prom [PROM_BYTES];
  logic [7:0] pmem [PMEM_BYTES];

  logic [ADDR_W-1:0] rsarQ, baseAddr, rsarStep, rsarAdv, stopAddr, startAddr;
  logic [CNT_W-1:0]  cntQ, cntAdv;
  logic [2:0]        xferLen;
  logic              access, wrEn, adrWr, cntWr;

  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [PM_AW-1:0]  pmIdx    [LANES];
  logic [PR_AW-1:0]  prIdx    [LANES];
  logic              laneOn   [LANES];
  logic              inProm   [LANES];
  logic              inPmem   [LANES];

  assign xferLen   = dpWide ? 3'd4 : (strobe.wordMode ? 3'd2 : 3'd1);
  assign baseAddr  = (xferLen == 3'd1) ? rsarQ : {rsarQ[ADDR_W-1:1], 1'b0};
  assign cntZero   = (cntQ == '0);
  assign access    = dpRd || (dpWr && !cntZero);
  assign wrEn      = dpWr && !cntZero;
  assign adrWr     = strobe.adrLoWr || strobe.adrHiWr;
  assign cntWr     = strobe.cntLoWr || strobe.cntHiWr;
  assign stopAddr  = ADDR_W'({strobe.stopPage, 8'h00});
  assign startAddr = ADDR_W'({strobe.startPage, 8'h00});
  assign rsarStep  = rsarQ + ADDR_W'(xferLen);
  assign rsarAdv   = (rsarStep == stopAddr) ? startAddr : rsarStep;
  assign dmaDone   = access && (cntQ <= CNT_W'(xferLen));
  assign cntAdv    = dmaDone ? '0 : cntQ - CNT_W'(xferLen);
  assign rsar      = rsarQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneAddr[g] = baseAddr + ADDR_W'(g);
    assign laneOn[g]   = (3'(g) < xferLen);
    assign inProm[g]   = laneAddr[g] < PROM_END;
    assign inPmem[g]   = (laneAddr[g] >= PMEM_LO) && (laneAddr[g] < PMEM_HI);
    assign pmIdx[g]    = PM_AW'(laneAddr[g] - PMEM_LO);
    assign prIdx[g]    = laneAddr[g][PR_AW-1:0];
    assign dpRdata[8*g +: 8] = !laneOn[g] ? 8'h00 :
                               inProm[g]  ? prom[prIdx[g]] :
                               inPmem[g]  ? pmem[pmIdx[g]] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PROM_BYTES; i++) prom[i] <= 8'h00;
      for (int i = 0; i < PMEM_BYTES; i++) pmem[i] <= 8'h00;
    end else if (wrEn) begin
      for (int i = 0; i < LANES; i++) begin
        if (laneOn[i] && inProm[i])      prom[prIdx[i]] <= dpWdata[8*i +: 8];
        else if (laneOn[i] && inPmem[i]) pmem[pmIdx[i]] <= dpWdata[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsarQ <= '0;
      cntQ  <= '0;
    end else begin
      if (strobe.adrLoWr)      rsarQ <= {rsarQ[ADDR_W-1:8], strobe.data};
      else if (strobe.adrHiWr) rsarQ <= ADDR_W'({strobe.data, rsarQ[7:0]});
      else if (access)         rsarQ <= rsarAdv;
      if (strobe.cntLoWr)      cntQ <= {cntQ[CNT_W-1:8], strobe.data};
      else if (strobe.cntHiWr) cntQ <= CNT_W'({strobe.data, cntQ[7:0]});
      else if (access)         cntQ <= cntAdv;
    end
  end

  p_idle_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dpWr && !dpRd && cntZero && !adrWr && !cntWr) |=> (cntZero && $stable(rsarQ)));
  p_count_falls_r5: assert property (@(posedge clk) disable iff (!rstN)
    (access && !cntZero && !cntWr) |=> (cntQ < $past(cntQ)));
  p_done_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone && !cntWr) |=> cntZero);
  p_ring_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (access && !adrWr && strobe.startPage != strobe.stopPage) |=> (rsarQ != $past(stopAddr)));
endmodule

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
module rdma_port
  import rdma_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int CNT_W           = 16,
  parameter int PROM_BYTES      = 32,
  parameter int PMEM_START_PAGE = 4,
  parameter int PMEM_PAGES      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        dpWr,
  input  logic        dpRd,
  input  logic        dpWide,
  input  logic [31:0] dpWdata,
  output logic [31:0] dpRdata,
  output logic        irq
);
  localparam int END_PAGE = PMEM_START_PAGE + PMEM_PAGES;

  rdma_strobe_t      strobe;
  logic [ADDR_W-1:0] rsar;
  logic              cntZero, dmaDone;

  rdma_ctrl #(.ADDR_W(ADDR_W), .END_PAGE(END_PAGE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .rsar(rsar), .cntZero(cntZero), .dmaDone(dmaDone),
    .regRdata(regRdata), .strobe(strobe), .irq(irq)
  );

  rdma_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PROM_BYTES(PROM_BYTES),
    .PMEM_START_PAGE(PMEM_START_PAGE), .PMEM_PAGES(PMEM_PAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dpWr(dpWr), .dpRd(dpRd),
    .dpWide(dpWide), .dpWdata(dpWdata), .dpRdata(dpRdata), .rsar(rsar),
    .cntZero(cntZero), .dmaDone(dmaDone)
  );
endmodule

// File: tb/rdma_port_tb.sv
`timescale 1ns/1ps
module rdma_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        dpWr = 1'b0, dpRd = 1'b0, dpWide = 1'b0;
  logic [31:0] dpWdata = '0;
  logic [31:0] dpRdata;
  logic        irq;

  int nChecks = 0, nFail = 0;

  // Behavioural reference state
  int mCmd = 1, mStat = 'h80, mMask = 0, mCfg = 0, mStart = 0, mStop = 0, mRsar = 0, mCnt = 0;
  bit [7:0] mMem [int];

  always #5 clk = ~clk;

  rdma_port u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .dpWr(dpWr), .dpRd(dpRd), .dpWide(dpWide),
    .dpWdata(dpWdata), .dpRdata(dpRdata), .irq(irq)
  );

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit backed(int a);
    return (a < 32) || (a >= 'h400 && a < 'h800);
  endfunction

  function automatic int xlen(bit wide);
    return wide ? 4 : ((mCfg & 1) ? 2 : 1);
  endfunction

  function automatic int lanebase(bit wide);
    return (xlen(wide) == 1) ? mRsar : (mRsar & 'hFFFE);
  endfunction

  function automatic longint dpExpect(bit wide);
    longint v = 0;
    for (int i = 0; i < xlen(wide); i++) begin
      int a = (lanebase(wide) + i) & 'hFFFF;
      longint b = !backed(a) ? 'hFF : (mMem.exists(a) ? mMem[a] : 0);
      v |= b << (8 * i);
    end
    return v;
  endfunction

  task automatic dpApply(bit isWr, bit wide, int data);
    int n = xlen(wide);
    if (isWr && mCnt == 0) return;
    if (isWr)
      for (int i = 0; i < n; i++) begin
        int a = (lanebase(wide) + i) & 'hFFFF;
        if (backed(a)) mMem[a] = 8'((data >> (8 * i)) & 'hFF);
      end
    mRsar = (mRsar + n) & 'hFFFF;
    if (mRsar == mStop * 256) mRsar = mStart * 256;
    if (mCnt <= n) begin mCnt = 0; mStat |= 'h40; end
    else mCnt -= n;
  endtask

  function automatic int regExpect(int off);
    int pg = (mCmd >> 6) & 3;
    if (off == 0) return mCmd;
    if (pg == 0) begin
      if (off == 7) return mStat;
      if (off == 8) return mRsar & 'hFF;
      if (off == 9) return (mRsar >> 8) & 'hFF;
    end else if (pg == 2) begin
      if (off == 1) return mStart;
      if (off == 2) return mStop;
      if (off == 'hE) return mCfg;
      if (off == 'hF) return mMask;
    end
    return 0;
  endfunction

  task automatic regApply(int off, int v);
    int pg = (mCmd >> 6) & 3;
    if (off == 0) begin
      mCmd = v;
      if ((v & 1) == 0) begin
        mStat &= 'h7F;
        if ((v & 'h18) != 0 && mCnt == 0) mStat |= 'h40;
      end
    end else if (pg == 0) begin
      case (off)
        1: if (v <= 8) mStart = v;
        2: if (v <= 8) mStop = v;
        7: mStat &= ~(v & 'h7F) & 'hFF;
        8: mRsar = (mRsar & 'hFF00) | v;
        9: mRsar = (mRsar & 'hFF) | (v << 8);
        'hA: mCnt = (mCnt & 'hFF00) | v;
        'hB: mCnt = (mCnt & 'hFF) | (v << 8);
        'hE: mCfg = v;
        'hF: mMask = v;
        default: ;
      endcase
    end
  endtask

  // One clock: drive at the falling edge, compare before the rising edge, advance the model.
  task automatic step(bit rw, int off, int d, bit pw, bit pr, bit wide, int pd,
                      bit chkReg, string tag);
    @(negedge clk);
    regWr = rw; regAddr = 4'(off); regWdata = 8'(d);
    dpWr = pw; dpRd = pr; dpWide = wide; dpWdata = 32'(pd);
    #2;
    check("R9 irq", irq, ((mStat & mMask & 'h7F) != 0));
    if (chkReg) check(tag, regRdata, regExpect(off));
    if (pr) check(tag, dpRdata, dpExpect(wide));
    if (rw) regApply(off, d);
    if (pw || pr) dpApply(pw, wide, pd);
    @(posedge clk);
    #1;
    regWr = 0; dpWr = 0; dpRd = 0;
  endtask

  task automatic wr(int off, int d);      step(1, off, d, 0, 0, 0, 0, 0, "");  endtask
  task automatic rd(int off, string tag); step(0, off, 0, 0, 0, 0, 0, 1, tag); endtask
  task automatic pwr(bit wide, int d);    step(0, 0, 0, 1, 0, wide, d, 0, ""); endtask
  task automatic prd(bit wide, string tag); step(0, 0, 0, 0, 1, wide, 0, 0, tag); endtask
  task automatic setAdr(int a, int c);
    wr(8, a & 'hFF); wr(9, (a >> 8) & 'hFF); wr('hA, c & 'hFF); wr('hB, (c >> 8) & 'hFF);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state
    rd(0, "R1 cmd"); rd(7, "R1 status"); rd(8, "R1 adr lo"); rd(9, "R1 adr hi");
    // R8 bit 7 not cleared by status write
    wr(7, 'h80); rd(7, "R8 reset flag kept");
    // R7 run clears reset flag
    wr(0, 'h22); rd(7, "R7 reset flag cleared");
    // R11 page limits
    wr(1, 4); wr(2, 8); wr(1, 9); wr(2, 'h20);
    wr(0, 'hA2); rd(1, "R11 start page"); rd(2, "R11 stop page");
    wr(1, 5); rd(1, "R2 page2 write ignored");
    wr(0, 'h62); rd(8, "R2 page1 read zero"); rd(7, "R2 page1 read zero");
    wr(0, 'h22); rd(3, "R2 unimplemented");
    wr('hF, 'h40);
    // R5 byte transfers, count exhaustion, R6 idle write
    setAdr('h400, 3);
    pwr(0, 'h11); pwr(0, 'h22); pwr(0, 'h33);
    rd(7, "R5 done flag");
    pwr(0, 'h44);
    rd(8, "R6 adr lo frozen"); rd(9, "R6 adr hi frozen");
    wr(7, 'h40); rd(7, "R8 done cleared");
    // R3 byte read back
    setAdr('h400, 4);
    prd(0, "R3 byte0"); prd(0, "R3 byte1"); prd(0, "R3 byte2"); prd(0, "R6 byte3 untouched");
    rd(8, "R4 advance");
    // R3 word mode with odd address
    wr('hE, 1); wr(0, 'hA2); rd('hE, "R2 cfg readback"); wr(0, 'h22);
    setAdr('h411, 4);
    pwr(0, 'hBEEF); pwr(0, 'h1234);
    rd(8, "R3 word advance"); rd(7, "R5 done word");
    setAdr('h410, 8);
    prd(1, "R3 wide read"); prd(0, "R3 word read");
    // R4 ring wrap
    setAdr('h7FC, 8);
    pwr(1, 'hA1B2C3D4);
    rd(8, "R4 wrap lo"); rd(9, "R4 wrap hi");
    prd(1, "R3 wide after wrap");
    // R10 unbacked lanes
    setAdr('h7FE, 4);
    prd(1, "R10 tail lanes");
    wr('hE, 0);
    setAdr('h100, 2);
    pwr(0, 'h5A);
    wr(8, 0); wr(9, 1);
    prd(0, "R10 hole read");
    setAdr('h1F, 2);
    pwr(0, 'h77);
    wr(8, 'h1F); wr(9, 0);
    prd(0, "R10 station area"); prd(0, "R10 past station area");
    // R7 remote command with zero count
    setAdr('h400, 0);
    wr(7, 'h7F); rd(7, "R8 all cleared");
    wr(0, 'h0A); rd(7, "R7 immediate done");
    wr(7, 'h40); wr(0, 'h09); rd(7, "R7 stop blocks done");
    // R9 mask off
    wr(0, 'h0A); wr('hF, 0); rd(7, "R9 status set, masked");
    wr('hF, 'h7F); rd(0, "R9 unmasked");
    summary();
    $finish;
  end
endmodule